// File: doc/BRIEF.md
# DRAM Cycle Decoder with Refresh Counter

This block is the control logic on the device side of a DRAM with a multiplexed address bus. A small array stands in for the cell array. The block samples the active-low strobes (row strobe, column strobe, write enable, output enable) on a system clock and finds their edges. It latches the row and then the column address, and works out what kind of cycle the controller started from the order of the edges. The result is reported as a one-cycle code. The block controls the direction of the shared data pins, which are modelled as separate in, out and enable signals. It keeps its own refresh row counter, used by refresh cycles started with the column strobe first and by self refresh.

A memory controller model or an interface bench uses this block to check that its strobe sequences produce the intended cycle type. The cycle types are:
- read and early write;
- read-modify-write;
- page-mode accesses;
- row-only refresh;
- counter-driven refresh, including the hidden refresh that follows a read;
- self refresh.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: After reset, and while both the row and column strobes stay high, `dq_oe` is 0, `cyc_valid` is 0 and `refresh_stb` is 0.
- R2: A row strobe fall latches `addr` as the row. A column strobe fall that follows, with write enable high, reports code 1 (read) and drives the stored byte of (row, `addr`) on `dq_out`. `dq_oe` is 1 only while both the column strobe and output enable are low.
- R3: Write enable low at the column strobe fall reports code 2 (early write) and stores `dq_in` taken at that fall. `dq_oe` stays 0 for the whole column cycle, even with output enable low.
- R4: Write enable falling while the column strobe is low during a read reports code 3 (read-write). It stores `dq_in` taken at the write enable fall. `dq_out` and `dq_oe` keep the data read earlier while the column and output enable strobes stay low.
- R5: Any further column strobe fall while the row strobe stays low uses the latched row. It reports code 4 for a page read and code 5 for a page write.
- R6: A row strobe rise with no column access since the row strobe fell reports code 6 (row-only refresh). It pulses `refresh_stb` with `refresh_row` equal to the latched row.
- R7: A row strobe fall while the column strobe is already low, with no read open, reports code 7. It pulses `refresh_stb` with the internal counter value as `refresh_row`, then increments the counter. The counter is 0 after reset.
- R8: A row strobe fall while the column strobe is still low from a read reports code 8 (hidden refresh). It uses and advances the same counter, while `dq_oe` and `dq_out` keep the read data.
- R9: If the row strobe stays low for SELF_HOLD clocks after a code-7 or code-8 cycle, the block reports code 9 and enters self refresh. It then pulses `refresh_stb` every SELF_PERIOD clocks with the next counter rows. A row strobe rise ends self refresh, and no more strobes follow.
- R10: Every code and refresh pulse appears on the clock edge that first samples the strobe change that causes it, and lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Data arriving on the shared pins |
| dq_out | output | DATA_W | Data sent to the shared pins |
| dq_oe | output | 1 | Pin drive enable |
| cyc_valid | output | 1 | One-clock pulse with a cycle code |
| cyc_code | output | 4 | Cycle type code |
| refresh_stb | output | 1 | One-clock pulse for each refreshed row |
| refresh_row | output | ROW_W | Row refreshed with `refresh_stb` |

## Verification
Several strobe orders are applied to the same row so that each pair of neighbouring cycle types gets separated:
- Write enable before versus after the column strobe separates early write from read-write.
- A first versus a repeated column fall separates plain accesses from page accesses.
- A column strobe that is low at the row fall, with or without an open read, separates counter refresh from hidden refresh.
- A row pulse with no column fall exposes row-only refresh.
- Holding the row strobe low past the hold time separates self refresh from a plain counter refresh, and the rows that follow show that the counter advances in one sequence across all three counter-driven paths.

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl #(
  parameter int ROW_W       = 11,
  parameter int DATA_W      = 8,
  parameter int MRA         = 3,
  parameter int MCA         = 3,
  parameter int SELF_HOLD   = 16,
  parameter int SELF_PERIOD = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              cyc_valid,
  output logic [3:0]        cyc_code,
  output logic              refresh_stb,
  output logic [ROW_W-1:0]  refresh_row
);
  localparam int DEPTH = 1 << (MRA + MCA);
  localparam int TMAX  = (SELF_HOLD > SELF_PERIOD) ? SELF_HOLD : SELF_PERIOD;
  localparam int TW    = $clog2(TMAX) + 1;
  localparam logic [TW-1:0] HOLD_LAST = TW'(SELF_HOLD - 1);
  localparam logic [TW-1:0] PER_LAST  = TW'(SELF_PERIOD - 1);

  localparam logic [3:0] C_READ = 4'd1, C_EWR = 4'd2, C_RMW = 4'd3, C_PRD = 4'd4,
                         C_PWR = 4'd5, C_RONLY = 4'd6, C_CBR = 4'd7, C_HID = 4'd8,
                         C_SELF = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_ROW, S_CBR, S_SELF} st_t;

  st_t               st;
  logic              ras_q, cas_q, we_q, oe_q;
  logic [ROW_W-1:0]  row_reg, rcnt;
  logic [MCA-1:0]    col_reg;
  logic              col_seen, rd_open;
  logic [TW-1:0]     tmr;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_data;

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic in_row, acc, rmw, wr_en;
  logic [MRA+MCA-1:0] idx_new, idx_old, wr_idx;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign cas_rise = ~cas_q & cas_n;
  assign we_fall  = we_q & ~we_n;

  assign idx_new = {row_reg[MRA-1:0], addr[MCA-1:0]};
  assign idx_old = {row_reg[MRA-1:0], col_reg};
  assign in_row  = (st == S_ROW) && !ras_rise;
  assign acc     = in_row && cas_fall;
  assign rmw     = in_row && !cas_fall && we_fall && !cas_n && rd_open;
  assign wr_en   = (acc && !we_n) || rmw;
  assign wr_idx  = acc ? idx_new : idx_old;

  assign dq_out = rd_data;
  assign dq_oe  = rd_open & ~cas_q & ~oe_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= dq_in;
    if (acc && we_n) rd_data <= mem[idx_new];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {ras_q, cas_q, we_q, oe_q} <= 4'hF;
      row_reg <= '0;
      rcnt <= '0;
      col_reg <= '0;
      col_seen <= 1'b0;
      rd_open <= 1'b0;
      tmr <= '0;
      cyc_valid <= 1'b0;
      cyc_code <= 4'd0;
      refresh_stb <= 1'b0;
      refresh_row <= '0;
    end else begin
      {ras_q, cas_q, we_q, oe_q} <= {ras_n, cas_n, we_n, oe_n};
      cyc_valid <= 1'b0;
      cyc_code <= 4'd0;
      refresh_stb <= 1'b0;
      if (cas_rise) rd_open <= 1'b0;
      unique case (st)
        S_IDLE: if (ras_fall) begin
          if (!cas_n) begin
            st <= S_CBR;
            tmr <= '0;
            refresh_stb <= 1'b1;
            refresh_row <= rcnt;
            rcnt <= rcnt + 1'b1;
            cyc_valid <= 1'b1;
            cyc_code <= rd_open ? C_HID : C_CBR;
          end else begin
            st <= S_ROW;
            row_reg <= addr;
            col_seen <= 1'b0;
          end
        end
        S_ROW: begin
          if (ras_rise) begin
            st <= S_IDLE;
            if (!col_seen) begin
              cyc_valid <= 1'b1;
              cyc_code <= C_RONLY;
              refresh_stb <= 1'b1;
              refresh_row <= row_reg;
            end
          end else if (cas_fall) begin
            col_seen <= 1'b1;
            col_reg <= addr[MCA-1:0];
            rd_open <= we_n;
            cyc_valid <= 1'b1;
            if (col_seen) cyc_code <= we_n ? C_PRD : C_PWR;
            else          cyc_code <= we_n ? C_READ : C_EWR;
          end else if (rmw) begin
            cyc_valid <= 1'b1;
            cyc_code <= C_RMW;
          end
        end
        S_CBR: begin
          if (ras_rise) st <= S_IDLE;
          else if (tmr == HOLD_LAST) begin
            st <= S_SELF;
            tmr <= '0;
            cyc_valid <= 1'b1;
            cyc_code <= C_SELF;
          end else tmr <= tmr + 1'b1;
        end
        S_SELF: begin
          if (ras_rise) st <= S_IDLE;
          else if (tmr == PER_LAST) begin
            tmr <= '0;
            refresh_stb <= 1'b1;
            refresh_row <= rcnt;
            rcnt <= rcnt + 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_cycle_chk.sv
module dram_cycle_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             cyc_valid,
  input logic [3:0]       cyc_code,
  input logic             refresh_stb,
  input logic [ROW_W-1:0] refresh_row
);
  logic             seen;
  logic [ROW_W-1:0] last_row;
  logic             ctr_stb;

  assign ctr_stb = refresh_stb && !(cyc_valid && cyc_code == 4'd6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      last_row <= '0;
    end else if (ctr_stb) begin
      seen <= 1'b1;
      last_row <= refresh_row;
    end
  end

  a_r2_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!oe_n || $past(!oe_n)));

  a_r3_ewrite_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_code == 4'd2) |-> !dq_oe);

  a_r6_ronly_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_code == 4'd6) |-> (refresh_stb && $past(ras_n)));

  a_r7_cbr_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_code == 4'd7 || cyc_code == 4'd8)) |->
      (refresh_stb && $past(!cas_n) && $past(!ras_n)));

  a_r7_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_stb && seen) |-> (refresh_row == last_row + 1'b1));

  a_r9_self_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_code == 4'd9) |-> ($past(!ras_n) && !refresh_stb));
endmodule

bind dram_cycle_ctrl dram_cycle_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
  .dq_oe(dq_oe), .cyc_valid(cyc_valid), .cyc_code(cyc_code),
  .refresh_stb(refresh_stb), .refresh_row(refresh_row)
);

// File: tb/tb_dram_cycle_ctrl.sv
module tb_dram_cycle_ctrl;
  localparam int H = 16;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe, cyc_valid, refresh_stb;
  logic [3:0]  cyc_code;
  logic [10:0] refresh_row;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_cycle_ctrl #(.ROW_W(11), .DATA_W(8), .MRA(3), .MCA(3),
                    .SELF_HOLD(H), .SELF_PERIOD(P)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_valid(cyc_valid), .cyc_code(cyc_code), .refresh_stb(refresh_stb),
    .refresh_row(refresh_row));

  // behavioural reference model
  int m_mode;            // 0 standby, 1 row open, 2 refresh hold, 3 self
  bit p_ras, p_cas, p_we, m_rd, m_seen;
  int m_row, m_col, m_cnt, m_wait;
  logic [7:0] m_mem [int];
  logic [7:0] e_dout;
  bit e_valid, e_stb, e_oe;
  int e_code, e_row;

  task automatic emit(int code);
    e_valid = 1; e_code = code;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; p_ras = 1; p_cas = 1; p_we = 1; m_rd = 0; m_seen = 0;
      m_cnt = 0; m_wait = 0; e_valid = 0; e_stb = 0; e_oe = 0; e_row = 0; e_code = 0;
    end else begin
      bit rf, rr, cf, cr, wf;
      rf = p_ras && !ras_n; rr = !p_ras && ras_n;
      cf = p_cas && !cas_n; cr = !p_cas && cas_n; wf = p_we && !we_n;
      e_valid = 0; e_stb = 0; e_code = 0;
      if (cr) m_rd = 0;
      if (m_mode == 0 && rf) begin
        if (!cas_n) begin
          emit(m_rd ? 8 : 7); e_stb = 1; e_row = m_cnt; m_cnt = (m_cnt + 1) % 2048;
          m_mode = 2; m_wait = 0;
        end else begin
          m_mode = 1; m_row = addr; m_seen = 0;
        end
      end else if (m_mode == 1) begin
        if (rr) begin
          m_mode = 0;
          if (!m_seen) begin emit(6); e_stb = 1; e_row = m_row; end
        end else if (cf) begin
          int k;
          k = (m_row % 8) * 8 + (addr % 8);
          emit(m_seen ? (we_n ? 4 : 5) : (we_n ? 1 : 2));
          m_seen = 1; m_col = addr % 8; m_rd = we_n;
          if (we_n) e_dout = m_mem.exists(k) ? m_mem[k] : 8'hxx;
          else m_mem[k] = dq_in;
        end else if (wf && !cas_n && m_rd) begin
          emit(3);
          m_mem[(m_row % 8) * 8 + m_col] = dq_in;
        end
      end else if (m_mode == 2) begin
        if (rr) m_mode = 0;
        else begin
          m_wait++;
          if (m_wait == H) begin emit(9); m_mode = 3; m_wait = 0; end
        end
      end else if (m_mode == 3) begin
        if (rr) m_mode = 0;
        else begin
          m_wait++;
          if (m_wait == P) begin
            m_wait = 0; e_stb = 1; e_row = m_cnt; m_cnt = (m_cnt + 1) % 2048;
          end
        end
      end
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
      e_oe = m_rd && !cas_n && !oe_n;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R10: every clock the outputs match the model on the edge of the cause
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 dq_oe", dq_oe, e_oe);
      chk("R10 valid", cyc_valid, e_valid);
      if (e_valid) chk("R10 code", cyc_code, e_code);
      chk("R10 refresh_stb", refresh_stb, e_stb);
      if (e_stb) chk("R10 refresh_row", refresh_row, e_row);
      if (e_oe) chk("R10 dq_out", dq_out, e_dout);
    end
  end

  task automatic step(bit r, bit c, bit w, bit o, int a, int d);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = 11'(a); dq_in = 8'(d);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int stb_seen;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    chk("R1 reset dq_oe", dq_oe, 0);
    chk("R1 reset valid", cyc_valid, 0);
    chk("R1 reset refresh_stb", refresh_stb, 0);
    step(1, 1, 1, 0, 0, 0);
    chk("R1 standby dq_oe", dq_oe, 0);

    // early write then page write, row 2
    step(0, 1, 1, 1, 2, 0);
    step(0, 1, 0, 0, 5, 'hA5);
    step(0, 0, 0, 0, 5, 'hA5);
    chk("R3 code", cyc_code, 2);
    chk("R3 no drive", dq_oe, 0);
    step(0, 0, 0, 0, 5, 'h00);
    chk("R3 still no drive", dq_oe, 0);
    step(0, 1, 0, 0, 5, 0);
    step(0, 0, 0, 0, 6, 'h3C);
    chk("R5 page write code", cyc_code, 5);
    step(0, 1, 1, 1, 6, 0);
    step(1, 1, 1, 1, 0, 0);
    chk("R5 no refresh on active row", refresh_stb, 0);

    // read, output enable toggle, page read, read-write
    step(0, 1, 1, 0, 2, 0);
    step(0, 0, 1, 0, 5, 0);
    chk("R2 code", cyc_code, 1);
    chk("R2 drive", dq_oe, 1);
    chk("R2 data", dq_out, 'hA5);
    step(0, 0, 1, 1, 5, 0);
    chk("R2 oe high stops drive", dq_oe, 0);
    step(0, 0, 1, 0, 5, 0);
    chk("R2 oe low drives again", dq_oe, 1);
    step(0, 1, 1, 0, 6, 0);
    chk("R2 cas high stops drive", dq_oe, 0);
    step(0, 0, 1, 0, 6, 0);
    chk("R5 page read code", cyc_code, 4);
    chk("R5 page read data", dq_out, 'h3C);
    step(0, 0, 0, 0, 6, 'h77);
    chk("R4 code", cyc_code, 3);
    chk("R4 keeps read data", dq_out, 'h3C);
    chk("R4 keeps drive", dq_oe, 1);
    step(0, 1, 1, 0, 6, 0);
    step(1, 1, 1, 1, 0, 0);
    step(0, 1, 1, 0, 2, 0);
    step(0, 0, 1, 0, 6, 0);
    chk("R4 stored write data", dq_out, 'h77);
    step(0, 1, 1, 0, 6, 0);
    step(1, 1, 1, 1, 0, 0);

    // hidden refresh after a read
    step(0, 1, 1, 0, 2, 0);
    step(0, 0, 1, 0, 5, 0);
    step(1, 0, 1, 0, 5, 0);
    chk("R8 drive across row high", dq_oe, 1);
    step(0, 0, 1, 0, 5, 0);
    chk("R8 code", cyc_code, 8);
    chk("R8 counter row", refresh_row, 0);
    chk("R8 drive held", dq_oe, 1);
    chk("R8 data held", dq_out, 'hA5);
    step(1, 0, 1, 0, 0, 0);
    step(1, 1, 1, 1, 0, 0);

    // counter refresh twice
    step(1, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    chk("R7 code", cyc_code, 7);
    chk("R7 row", refresh_row, 1);
    step(1, 0, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0, 0);
    step(1, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    chk("R7 increments", refresh_row, 2);
    step(1, 0, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0, 0);

    // row-only refresh
    step(0, 1, 1, 0, 'h155, 0);
    chk("R6 nothing on fall", cyc_valid, 0);
    step(1, 1, 1, 0, 0, 0);
    chk("R6 code", cyc_code, 6);
    chk("R6 row", refresh_row, 'h155);
    chk("R6 no drive", dq_oe, 0);

    // self refresh
    step(1, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    chk("R9 entry refresh row", refresh_row, 3);
    for (int i = 1; i < H; i++) step(0, 0, 1, 1, 0, 0);
    chk("R9 not yet self", cyc_valid, 0);
    step(0, 0, 1, 1, 0, 0);
    chk("R9 self code", cyc_code, 9);
    for (int i = 1; i < P; i++) step(0, 0, 1, 1, 0, 0);
    chk("R9 no early strobe", refresh_stb, 0);
    step(0, 0, 1, 1, 0, 0);
    chk("R9 first self strobe", refresh_stb, 1);
    chk("R9 first self row", refresh_row, 4);
    for (int i = 0; i < P; i++) step(0, 0, 1, 1, 0, 0);
    chk("R9 second self row", refresh_row, 5);
    step(1, 0, 1, 1, 0, 0);
    stb_seen = 0;
    for (int i = 0; i < 2 * P; i++) begin
      step(1, 0, 1, 1, 0, 0);
      stb_seen += refresh_stb;
    end
    chk("R9 exit stops strobes", stb_seen, 0);
    step(1, 1, 1, 1, 0, 0);
    chk("R1 back to standby", dq_oe, 0);
    step(1, 1, 1, 1, 0, 0);
    finish_run();
  end
endmodule